// File: doc/BRIEF.md
# Serial Management Frame to Register Bus Bridge

This block is the slave side of a two-wire serial management link. It takes the management data bit sampled on a clock enable that marks each management clock edge. It parses Clause 22 style read and write frames addressed to its own device address. Each accepted frame becomes exactly one classic Wishbone cycle toward a register file. For reads, the block drives the turnaround zero and the sixteen register data bits back onto the serial line through a data/enable pair. The physical pin buffers sit outside the block.

The frame is walked by a single down-counter. The counter first counts preamble ones. It then counts the bits left in each field: start, opcode, device address, register address, turnaround and data. A frame that is malformed or meant for another device still steps through every field. Bit alignment is therefore never lost, and such a frame never reaches the bus. A bus error on a read keeps the serial output released for that whole read. The error is held in a register until the next bit boundary, where it takes effect.

Top module: `mdio_bus_bridge`

## Requirements
- R1: After reset the serial output enable is low and no bus cycle is open (cyc and stb low).
- R2: A frame is recognised only after at least 32 consecutive ones followed by the start pattern 0 then 1. A frame preceded by only 31 ones is ignored entirely: no bus cycle and no output enable. Longer runs of ones are accepted.
- R3: A well-formed read (opcode bits 1 then 0) whose 5-bit device address, sent MSB first, matches the address input starts one bus read (we low). The bus address is the 5-bit register address sent MSB first. The cycle opens at the clock edge that samples the last register address bit.
- R4: On a served read, the output enable is low during the first turnaround bit time. The block then drives 0 for the second turnaround bit. It then drives the 16 returned data bits MSB first, one per bit time, and releases the line after the last data bit.
- R5: A well-formed write (opcode bits 0 then 1) to this device collects 16 data bits MSB first. After the last data bit it starts one bus write carrying that register address and data.
- R6: A frame whose device address differs from the address input issues no bus cycle and never asserts the output enable. The frame still consumes all its bits, so a following valid frame is served.
- R7: A frame with a bad second start bit, or with opcode 00 or 11, issues no bus cycle and never asserts the output enable. It still runs its full length, so a following valid frame is served.
- R8: If the bus answers a read with err, the output enable stays low for the whole frame. The output enable is never high while a bus cycle is open.
- R9: If the bus answers a write with err, the bridge takes no further action and serves the next frame normally.
- R10: A bus cycle keeps cyc, stb, we, address and write data steady until ack or err. It closes on the next clock edge after the response, and each accepted frame opens exactly one cycle.
- R11: After the last bit of a frame, no new frame is looked for until the open bus cycle has answered. Bits that arrive while waiting are discarded.
- R12: If a read has not been answered by the end of the first turnaround bit, the block does not drive the line for that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | One-cycle strobe marking a management clock rising edge |
| mdi | input | 1 | Sampled management data bit |
| phy_addr | input | ADDR_W | Device address this bridge answers to |
| mdo | output | 1 | Serial data to drive |
| mdo_oe | output | 1 | Serial output enable |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | ADDR_W | Bus register address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_ack | input | 1 | Bus acknowledge |
| wb_err | input | 1 | Bus error response |
| wb_dat_i | input | DATA_W | Bus read data |

## Verification
Writes followed by reads of values with mixed bits, a lone top bit and a lone bottom bit show that data is gathered and returned MSB first, and that the turnaround timing is right. Frames with 31 against 40 preamble ones, a foreign device address, a bad start bit and both illegal opcodes show that frames are rejected without losing alignment: each is followed by a valid read that must still be served. The bench register slave returns err for register addresses 24 and up, and its response delay can be set. Error and slow answers on reads and writes separate a suppressed read reply from a late one. They also show that frames arriving while a write is still outstanding are dropped.

// File: rtl/mdio_bridge_pkg.sv
// Shared types and helpers for the serial management bridge.
// Assumes field widths are small enough that a single counter covers them.
package mdio_bridge_pkg;

    // Frame field sequencer states
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_OP,
        FS_PHY,
        FS_REG,
        FS_TA,
        FS_DATA,
        FS_WAIT
    } frame_st_e;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    // Counter width able to hold the largest field count minus one
    function automatic int cnt_width(input int a, input int b);
        int m;
        int w;
        m = (a > b) ? a : b;
        w = $clog2(m);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/mdio_frame_seq.sv
// Frame field sequencer. One down-counter tracks the preamble run and then
// the bits left in each field. Bad or foreign frames still run all fields.
// Assumes DATA_W >= 2 and mdi is only meaningful when ce is high.
module mdio_frame_seq
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              mdi,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              bus_busy,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_adr,
    output logic [DATA_W-1:0] req_dat,
    output logic              rd_ok_frame,
    output logic              ta_first,
    output logic              in_data,
    output logic              data_last
);

    localparam int CW  = cnt_width(PRE_LEN, DATA_W);
    localparam int SHW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam logic [CW-1:0] RELOAD_PRE  = CW'(PRE_LEN - 1);
    localparam logic [CW-1:0] RELOAD_ADR  = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] RELOAD_DAT  = CW'(DATA_W - 1);
    localparam logic [CW-1:0] RELOAD_TWO  = CW'(1);

    frame_st_e         st;
    logic [CW-1:0]     cnt;
    logic              cnt_zero;
    logic              pre_full;
    logic              bad;
    logic              mine;
    logic              op_rd;
    logic              op_wr;
    logic [SHW-1:0]    sh;
    logic [SHW-1:0]    sh_nx;
    logic [ADDR_W-1:0] reg_q;
    logic              frame_ok;

    assign sh_nx    = {sh[SHW-2:0], mdi};
    assign cnt_zero = (cnt == '0);
    assign frame_ok = !bad && mine;

    // Bus requests fire on the bit that completes the relevant field
    assign rd_req      = ce && (st == FS_REG)  && cnt_zero && op_rd && frame_ok;
    assign wr_req      = ce && (st == FS_DATA) && cnt_zero && op_wr && frame_ok;
    assign req_adr     = (st == FS_REG) ? sh_nx[ADDR_W-1:0] : reg_q;
    assign req_dat     = sh_nx[DATA_W-1:0];
    assign rd_ok_frame = op_rd && frame_ok;
    assign ta_first    = (st == FS_TA) && !cnt_zero;
    assign in_data     = (st == FS_DATA);
    assign data_last   = in_data && cnt_zero;

    // Field sequencing, one step per clock enable (waiting is not gated)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_IDLE;
            cnt      <= RELOAD_PRE;
            pre_full <= 1'b0;
            bad      <= 1'b0;
            mine     <= 1'b0;
            op_rd    <= 1'b0;
            op_wr    <= 1'b0;
            sh       <= '0;
            reg_q    <= '0;
        end else if (st == FS_WAIT) begin
            cnt      <= RELOAD_PRE;
            pre_full <= 1'b0;
            if (!bus_busy) begin
                st <= FS_IDLE;
            end
        end else if (ce) begin
            case (st)
                FS_IDLE: begin
                    if (mdi) begin
                        if (cnt_zero) pre_full <= 1'b1;
                        else          cnt      <= cnt - CW'(1);
                    end else if (pre_full) begin
                        st       <= FS_START;
                        pre_full <= 1'b0;
                        bad      <= 1'b0;
                        mine     <= 1'b0;
                        op_rd    <= 1'b0;
                        op_wr    <= 1'b0;
                    end else begin
                        cnt <= RELOAD_PRE;
                    end
                end
                FS_START: begin
                    if (!mdi) bad <= 1'b1;
                    st  <= FS_OP;
                    cnt <= RELOAD_TWO;
                end
                FS_OP: begin
                    sh <= sh_nx;
                    if (cnt_zero) begin
                        op_rd <= (sh_nx[1:0] == OPC_RD);
                        op_wr <= (sh_nx[1:0] == OPC_WR);
                        if (sh_nx[1:0] != OPC_RD && sh_nx[1:0] != OPC_WR) bad <= 1'b1;
                        st  <= FS_PHY;
                        cnt <= RELOAD_ADR;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                FS_PHY: begin
                    sh <= sh_nx;
                    if (cnt_zero) begin
                        mine <= (sh_nx[ADDR_W-1:0] == phy_addr);
                        st   <= FS_REG;
                        cnt  <= RELOAD_ADR;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                FS_REG: begin
                    sh <= sh_nx;
                    if (cnt_zero) begin
                        reg_q <= sh_nx[ADDR_W-1:0];
                        st    <= FS_TA;
                        cnt   <= RELOAD_TWO;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                FS_TA: begin
                    if (cnt_zero) begin
                        st  <= FS_DATA;
                        cnt <= RELOAD_DAT;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                FS_DATA: begin
                    sh <= sh_nx;
                    if (cnt_zero) begin
                        if (bus_busy || wr_req) begin
                            st <= FS_WAIT;
                        end else begin
                            st  <= FS_IDLE;
                            cnt <= RELOAD_PRE;
                        end
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    st  <= FS_IDLE;
                    cnt <= RELOAD_PRE;
                end
            endcase
        end
    end

endmodule

// File: rtl/mdio_wb_master.sv
// Classic single-cycle bus master. Opens one cycle per request and keeps
// the response (ok or error) until the next request, so a late answer
// survives until the sequencer's next bit boundary.
// Assumes a request never arrives while a cycle is open.
module mdio_wb_master #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [DATA_W-1:0] req_dat,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic              wb_ack,
    input  logic              wb_err,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              busy,
    output logic              resp_ok,
    output logic              resp_err,
    output logic [DATA_W-1:0] rdata
);

    assign busy = wb_cyc;

    // Cycle control and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_cyc   <= 1'b0;
            wb_stb   <= 1'b0;
            wb_we    <= 1'b0;
            wb_adr   <= '0;
            wb_dat_o <= '0;
            resp_ok  <= 1'b0;
            resp_err <= 1'b0;
            rdata    <= '0;
        end else if (!wb_cyc && (rd_req || wr_req)) begin
            wb_cyc   <= 1'b1;
            wb_stb   <= 1'b1;
            wb_we    <= wr_req;
            wb_adr   <= req_adr;
            wb_dat_o <= wr_req ? req_dat : '0;
            resp_ok  <= 1'b0;
            resp_err <= 1'b0;
        end else if (wb_cyc && (wb_ack || wb_err)) begin
            wb_cyc   <= 1'b0;
            wb_stb   <= 1'b0;
            resp_ok  <= wb_ack && !wb_err;
            resp_err <= wb_err;
            if (!wb_we && wb_ack && !wb_err) begin
                rdata <= wb_dat_i;
            end
        end
    end

endmodule

// File: rtl/mdio_tx_path.sv
// Read reply driver. Decides once, at the end of the first turnaround bit,
// whether this read is served; then drives 0 and shifts data out MSB first.
// Assumes the sequencer's phase flags are registered state.
module mdio_tx_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              ta_first,
    input  logic              in_data,
    input  logic              data_last,
    input  logic              rd_ok_frame,
    input  logic              resp_ok,
    input  logic              resp_err,
    input  logic [DATA_W-1:0] rdata,
    output logic              mdo,
    output logic              mdo_oe
);

    logic              drive;
    logic [DATA_W-1:0] tx_sh;

    assign mdo_oe = drive;
    assign mdo    = drive && in_data && tx_sh[DATA_W-1];

    // Drive decision and data shifting on bit boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= 1'b0;
            tx_sh <= '0;
        end else if (ce && ta_first) begin
            drive <= rd_ok_frame && resp_ok && !resp_err;
            tx_sh <= rdata;
        end else if (ce && in_data) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (data_last) drive <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_bus_bridge.sv
// Top level: serial management frames in, single bus cycles out, read
// replies back onto the serial line. Assumes ce is a one-cycle strobe per
// management clock rising edge and mdi is already synchronised.
module mdio_bus_bridge #(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              mdi,
    input  logic [ADDR_W-1:0] phy_addr,
    output logic              mdo,
    output logic              mdo_oe,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic              wb_ack,
    input  logic              wb_err,
    input  logic [DATA_W-1:0] wb_dat_i
);

    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] req_adr;
    logic [DATA_W-1:0] req_dat;
    logic              rd_ok_frame;
    logic              ta_first;
    logic              in_data;
    logic              data_last;
    logic              busy;
    logic              resp_ok;
    logic              resp_err;
    logic [DATA_W-1:0] rdata;

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (ce),
        .mdi         (mdi),
        .phy_addr    (phy_addr),
        .bus_busy    (busy),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .req_adr     (req_adr),
        .req_dat     (req_dat),
        .rd_ok_frame (rd_ok_frame),
        .ta_first    (ta_first),
        .in_data     (in_data),
        .data_last   (data_last)
    );

    mdio_wb_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .req_adr  (req_adr),
        .req_dat  (req_dat),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_ack   (wb_ack),
        .wb_err   (wb_err),
        .wb_dat_i (wb_dat_i),
        .busy     (busy),
        .resp_ok  (resp_ok),
        .resp_err (resp_err),
        .rdata    (rdata)
    );

    mdio_tx_path #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (ce),
        .ta_first    (ta_first),
        .in_data     (in_data),
        .data_last   (data_last),
        .rd_ok_frame (rd_ok_frame),
        .resp_ok     (resp_ok),
        .resp_err    (resp_err),
        .rdata       (rdata),
        .mdo         (mdo),
        .mdo_oe      (mdo_oe)
    );

endmodule

// File: rtl/mdio_bus_bridge_chk.sv
// Protocol checker for the bridge's bus and serial outputs; attached by bind.
module mdio_bus_bridge_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdo,
    input logic              mdo_oe,
    input logic              wb_cyc,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_ack,
    input logic              wb_err
);

    // Request fields stay steady while waiting for the answer
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && !wb_ack && !wb_err) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o)));

    // A cycle closes right after its answer
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && (wb_ack || wb_err)) |=> !wb_cyc);

    // The first driven bit of a reply is the turnaround zero
    assert_ta_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdo_oe) |-> !mdo);

    // The line is only driven once the bus has answered
    assert_oe_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mdo_oe |-> !wb_cyc);

    // An error answer on a read never leads to driving
    assert_err_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_err && !wb_we) |=> !mdo_oe);

endmodule

bind mdio_bus_bridge mdio_bus_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdo      (mdo),
    .mdo_oe   (mdo_oe),
    .wb_cyc   (wb_cyc),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_ack   (wb_ack),
    .wb_err   (wb_err)
);

// File: tb/tb_mdio_bus_bridge.sv
`timescale 1ns/1ps
module tb_mdio_bus_bridge;

    localparam logic [4:0] MY_PA = 5'h0B;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        mdi = 1'b1;
    logic [4:0]  phy_addr = MY_PA;
    logic        mdo;
    logic        mdo_oe;
    logic        wb_cyc;
    logic        wb_stb;
    logic        wb_we;
    logic [4:0]  wb_adr;
    logic [15:0] wb_dat_o;
    logic        wb_ack = 1'b0;
    logic        wb_err = 1'b0;
    logic [15:0] wb_dat_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic oe_s;
    logic mdo_s;

    // register slave model state
    logic [15:0] regs [32];
    int          slv_delay = 1;
    int          slv_wait = 0;
    int          bus_count = 0;
    logic [4:0]  last_adr = '0;
    logic        last_we = 1'b0;
    logic [15:0] last_dat = '0;

    always #2.5 clk = ~clk;

    mdio_bus_bridge dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .mdi      (mdi),
        .phy_addr (phy_addr),
        .mdo      (mdo),
        .mdo_oe   (mdo_oe),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_ack   (wb_ack),
        .wb_err   (wb_err),
        .wb_dat_i (wb_dat_i)
    );

    // Slave: answers after slv_delay negedges; addresses 24 and up answer err
    always @(negedge clk) begin
        if (!wb_cyc) begin
            wb_ack   = 1'b0;
            wb_err   = 1'b0;
            slv_wait = 0;
        end else if (!wb_ack && !wb_err) begin
            if (slv_wait >= slv_delay) begin
                bus_count = bus_count + 1;
                last_adr  = wb_adr;
                last_we   = wb_we;
                last_dat  = wb_dat_o;
                if (wb_adr >= 5'd24) begin
                    wb_err = 1'b1;
                end else begin
                    wb_ack = 1'b1;
                    if (wb_we) regs[wb_adr] = wb_dat_o;
                    else       wb_dat_i = regs[wb_adr];
                end
            end else begin
                slv_wait = slv_wait + 1;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One serial bit: present, strobe ce, then sample the outputs mid-bit
    task automatic send_bit(input logic b);
        @(negedge clk);
        mdi = b;
        ce  = 1'b1;
        @(negedge clk);
        ce  = 1'b0;
        repeat (3) @(negedge clk);
        oe_s  = mdo_oe;
        mdo_s = mdo;
    endtask

    task automatic frame(input int npre, input logic sbit, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rd, output logic ta_rel, output logic ta_zero,
                         output logic data_drv, output logic any_oe, output logic end_oe);
        logic is_wr;
        is_wr    = (op == OP_WR);
        any_oe   = 1'b0;
        data_drv = 1'b1;
        rd       = '0;
        for (int i = 0; i < npre; i++) begin
            send_bit(1'b1); any_oe |= oe_s;
        end
        send_bit(1'b0); any_oe |= oe_s;
        send_bit(sbit); any_oe |= oe_s;
        for (int i = 1; i >= 0; i--) begin
            send_bit(op[i]); any_oe |= oe_s;
        end
        for (int i = 4; i >= 0; i--) begin
            send_bit(pa[i]); any_oe |= oe_s;
        end
        for (int i = 4; i >= 0; i--) begin
            send_bit(ra[i]); any_oe |= oe_s;
        end
        ta_rel = !oe_s;
        send_bit(1'b1); any_oe |= oe_s;
        ta_zero = oe_s && !mdo_s;
        send_bit(is_wr ? 1'b0 : 1'b1); any_oe |= oe_s;
        rd[15]   = mdo_s;
        data_drv = oe_s;
        for (int i = 0; i < 16; i++) begin
            send_bit(is_wr ? wd[15-i] : 1'b1); any_oe |= oe_s;
            if (i < 15) begin
                rd[14-i] = mdo_s;
                data_drv &= oe_s;
            end else begin
                end_oe = oe_s;
            end
        end
    endtask

    task automatic wr_frame(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd, output logic any_oe);
        logic [15:0] rd;
        logic a, b, c, e;
        frame(32, 1'b1, OP_WR, pa, ra, wd, rd, a, b, c, any_oe, e);
        repeat (20) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1", "oe after reset", {31'd0, mdo_oe}, 32'd0);
        chk("R1", "cyc after reset", {31'd0, wb_cyc}, 32'd0);
        chk("R1", "stb after reset", {31'd0, wb_stb}, 32'd0);
    endtask

    task automatic test_write_read(input logic [4:0] ra, input logic [15:0] val);
        int bc;
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        bc = bus_count;
        wr_frame(MY_PA, ra, val, any);
        chk("R5", "write cycle count", bus_count, bc + 1);
        chk("R5", "write we", {31'd0, last_we}, 32'd1);
        chk("R5", "write address", {27'd0, last_adr}, {27'd0, ra});
        chk("R5", "write data", {16'd0, last_dat}, {16'd0, val});
        frame(32, 1'b1, OP_RD, MY_PA, ra, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        chk("R3", "read cycle count", bus_count, bc + 2);
        chk("R3", "read we", {31'd0, last_we}, 32'd0);
        chk("R3", "read address", {27'd0, last_adr}, {27'd0, ra});
        chk("R4", "first turnaround released", {31'd0, ta_rel}, 32'd1);
        chk("R4", "second turnaround zero", {31'd0, ta_zero}, 32'd1);
        chk("R4", "data enable", {31'd0, drv}, 32'd1);
        chk("R4", "data value", {16'd0, rd}, {16'd0, val});
        chk("R4", "released after data", {31'd0, eo}, 32'd0);
    endtask

    task automatic expect_read(input string req, input logic [4:0] ra, input logic [15:0] val);
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        frame(32, 1'b1, OP_RD, MY_PA, ra, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        chk(req, "follow-up read driven", {31'd0, drv}, 32'd1);
        chk(req, "follow-up read data", {16'd0, rd}, {16'd0, val});
    endtask

    task automatic expect_ignored(input string req, input string what, input int npre, input logic sbit,
                                  input logic [1:0] op, input logic [4:0] pa);
        int bc;
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        bc = bus_count;
        frame(npre, sbit, op, pa, 5'd3, 16'hFFFF, rd, ta_rel, ta_zero, drv, any, eo);
        repeat (20) @(negedge clk);
        chk(req, {what, " bus cycles"}, bus_count, bc);
        chk(req, {what, " output enable"}, {31'd0, any}, 32'd0);
    endtask

    task automatic test_preamble();
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        expect_ignored("R2", "31 ones", 31, 1'b1, OP_RD, MY_PA);
        frame(40, 1'b1, OP_RD, MY_PA, 5'd3, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        chk("R2", "40 ones read data", {16'd0, rd}, 32'h0000A5C3);
    endtask

    task automatic test_phy_mismatch();
        expect_ignored("R6", "foreign read", 32, 1'b1, OP_RD, MY_PA ^ 5'h01);
        expect_ignored("R6", "foreign write", 32, 1'b1, OP_WR, MY_PA ^ 5'h10);
        expect_read("R6", 5'd17, 16'h8000);
    endtask

    task automatic test_bad_frames();
        expect_ignored("R7", "opcode 11", 32, 1'b1, 2'b11, MY_PA);
        expect_ignored("R7", "opcode 00", 32, 1'b1, 2'b00, MY_PA);
        expect_ignored("R7", "bad start bit", 32, 1'b0, OP_RD, MY_PA);
        expect_read("R7", 5'd3, 16'hA5C3);
    endtask

    task automatic test_read_err();
        int bc;
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        bc = bus_count;
        frame(32, 1'b1, OP_RD, MY_PA, 5'd26, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        chk("R8", "error read cycle count", bus_count, bc + 1);
        chk("R8", "error read output enable", {31'd0, any}, 32'd0);
        expect_read("R8", 5'd3, 16'hA5C3);
    endtask

    task automatic test_write_err();
        int bc;
        logic any;
        bc = bus_count;
        wr_frame(MY_PA, 5'd28, 16'hFFFF, any);
        chk("R9", "error write cycle count", bus_count, bc + 1);
        chk("R9", "error write we", {31'd0, last_we}, 32'd1);
        expect_read("R9", 5'd3, 16'hA5C3);
    endtask

    task automatic test_slow_read();
        int bc;
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        bc = bus_count;
        slv_delay = 30;
        frame(32, 1'b1, OP_RD, MY_PA, 5'd3, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        slv_delay = 1;
        chk("R12", "late read cycle count", bus_count, bc + 1);
        chk("R12", "late read output enable", {31'd0, any}, 32'd0);
    endtask

    task automatic test_busy_wait();
        int bc;
        logic [15:0] rd;
        logic ta_rel, ta_zero, drv, any, eo;
        bc = bus_count;
        slv_delay = 500;
        frame(32, 1'b1, OP_WR, MY_PA, 5'd5, 16'h1234, rd, ta_rel, ta_zero, drv, any, eo);
        frame(32, 1'b1, OP_RD, MY_PA, 5'd3, 16'h0, rd, ta_rel, ta_zero, drv, any, eo);
        chk("R11", "read during wait output enable", {31'd0, any}, 32'd0);
        repeat (300) @(negedge clk);
        chk("R11", "only the write reached the bus", bus_count, bc + 1);
        slv_delay = 1;
        expect_read("R11", 5'd5, 16'h1234);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = '0;
        repeat (5) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_write_read(5'd3, 16'hA5C3);
        test_write_read(5'd17, 16'h8000);
        test_write_read(5'd9, 16'h0001);
        test_preamble();
        test_phy_mismatch();
        test_bad_frames();
        test_read_err();
        test_write_err();
        test_slow_read();
        test_busy_wait();
        summary();
        $finish;
    end

endmodule